// File: doc/BRIEF.md
# Clean-First Windowed LRU Victim Selector

This block chooses which way of one 16-way set is replaced on the next miss. It keeps a full recency ordering of the ways, plus a valid bit and a dirty bit for each way. Evicting a dirty line costs a writeback to a slow, write-expensive backing memory, so the selector holds on to dirty lines where it reasonably can. It looks at a window made up of the N least recently used positions and picks the oldest clean line found there. Only when every line in that window is dirty does it fall back to the true least recently used line, and in that case it flags the victim as dirty. The window size N is a run-time input, so software or a tuning controller can move the policy anywhere between plain LRU (N = 1) and "any clean line in the set" (N = 16).

Each cycle the owning cache controller presents either a hit or a miss with `acc_valid`. On a hit, `acc_way` names the way that was hit. On a miss, the line is filled into the way that `victim_way` shows in that same cycle. The write flag says whether the access stores data. The victim outputs are combinational from the stored state and the window input, so the controller sees them before it commits a miss.

Top module: `cfw_victim_sel`

## Requirements
- R1: After reset every way is invalid and clean, and the recency order runs from way 0 (least recent) up to way 15 (most recent). `victim_way` reads 0 and `victim_dirty` reads 0.
- R2: While any way is invalid, `victim_way` is the lowest-numbered invalid way and `victim_dirty` is 0, whatever the window input is.
- R3: Every access, hit or fill, moves the touched way to the most recent position, and the other ways keep their relative order. On a miss the touched way is the `victim_way` shown in the cycle of the access, and that way becomes valid.
- R4: A write hit sets the dirty bit of the hit way. A read hit leaves the dirty bit unchanged. A fill sets the dirty bit to the write flag: 1 for a write miss, 0 for a read miss.
- R5: When all ways are valid, `victim_way` is the least recently used clean way among the N least recently used positions, and `victim_dirty` is 0.
- R6: When all ways are valid and every way in the window is dirty, `victim_way` is the overall least recently used way and `victim_dirty` is 1.
- R7: With N = 1 the victim is always the least recently used way, which is exactly LRU replacement.
- R8: With N = 16 the window covers the whole set, so any clean way is chosen before a dirty one, the oldest clean way first.
- R9: `win_n` is a 5-bit unsigned value. The value 0 acts as 1, and values above 16 act as 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access to the set takes effect at this edge |
| acc_hit | input | 1 | 1: the access hit `acc_way`; 0: miss, fill into `victim_way` |
| acc_way | input | 4 | Way that was hit (ignored on a miss) |
| acc_write | input | 1 | The access stores data |
| win_n | input | 5 | Window size N, clamped into 1..16 |
| victim_way | output | 4 | Way to be replaced on the next miss |
| victim_dirty | output | 1 | The chosen victim holds modified data |

## Verification
The hardest case to reach from the ports is a full set in which the oldest several positions are all dirty and a clean line sits just outside the window. Only that case separates the fallback path from the clean search, and only there do the window size and its clamping change the answer. To reach it, the stimulus first fills all ways, then write-hits each way in turn so that the whole set is dirty in a known order. It then read-fills one way, which leaves a single clean line at the most recent end. Probing with several window sizes, including 0 and 31, then shows each decision. A long pseudo-random mix of hits, misses and window sizes follows, and an independent timestamp model checks every step of it.

// File: rtl/cfw_pkg.sv
package cfw_pkg;

  typedef enum logic [1:0] {
    SRC_INVALID = 2'd0,
    SRC_CLEAN   = 2'd1,
    SRC_LRU     = 2'd2
  } victim_src_e;

  // Window size used by the search: raw value forced into 1..ways.
  function automatic int unsigned clamp_window(int unsigned raw, int unsigned ways);
    if (raw == 0)
      return 1;
    else if (raw > ways)
      return ways;
    else
      return raw;
  endfunction

endpackage

// File: rtl/cfw_recency.sv
module cfw_recency #(
  parameter int WAYS = 16,
  parameter int IDXW = $clog2(WAYS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       touch_en,
  input  logic [IDXW-1:0]            touch_way,
  output logic [WAYS-1:0][IDXW-1:0]  order
);
  // order[0] is least recent, order[WAYS-1] is most recent.
  logic [WAYS-1:0]            at_or_above;
  logic [WAYS-1:0][IDXW-1:0]  order_nxt;
  logic [WAYS-1:0]            seen;

  always_comb begin
    logic run;
    run = 1'b0;
    for (int p = 0; p < WAYS; p++) begin
      run = run | (order[p] == touch_way);
      at_or_above[p] = run;
    end
  end

  generate
    for (genvar p = 0; p < WAYS - 1; p++) begin : g_shift
      assign order_nxt[p] = at_or_above[p] ? order[p+1] : order[p];
    end
  endgenerate
  assign order_nxt[WAYS-1] = touch_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < WAYS; p++) order[p] <= IDXW'(p);
    end else if (touch_en) begin
      order <= order_nxt;
    end
  end

  always_comb begin
    seen = '0;
    for (int p = 0; p < WAYS; p++) seen[order[p]] = 1'b1;
  end

  // R3: touched way lands at the most recent position
  assert_mru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> order[WAYS-1] == $past(touch_way));
  // R3: the list stays a permutation of all ways
  assert_perm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    &seen);
  // R3: untouched list is left alone
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !touch_en |=> $stable(order));

endmodule

// File: rtl/cfw_line_state.sv
module cfw_line_state #(
  parameter int WAYS = 16,
  parameter int IDXW = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_en,
  input  logic             acc_hit,
  input  logic             acc_wr,
  input  logic [IDXW-1:0]  touch_way,
  output logic [WAYS-1:0]  valid,
  output logic [WAYS-1:0]  dirty
);
  logic fill_ev;
  logic wr_hit_ev;
  assign fill_ev   = acc_en && !acc_hit;
  assign wr_hit_ev = acc_en && acc_hit && acc_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= '0;
      dirty <= '0;
    end else begin
      if (fill_ev) begin
        valid[touch_way] <= 1'b1;
        dirty[touch_way] <= acc_wr;
      end else if (wr_hit_ev) begin
        dirty[touch_way] <= 1'b1;
      end
    end
  end

  // R4: any write leaves the touched line dirty
  assert_wr_dirty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr) |=> dirty[$past(touch_way)]);
  // R4: a read fill leaves the line clean
  assert_rd_fill_clean_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_hit && !acc_wr) |=> !dirty[$past(touch_way)]);
  // R4: a read hit does not change the dirty bit
  assert_rd_hit_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_hit && !acc_wr) |=> $stable(dirty));
  // R3: a filled way is valid afterwards
  assert_fill_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ev |=> valid[$past(touch_way)]);

endmodule

// File: rtl/cfw_victim_pick.sv
module cfw_victim_pick
  import cfw_pkg::*;
#(
  parameter int WAYS = 16,
  parameter int IDXW = $clog2(WAYS),
  parameter int WINW = $clog2(WAYS) + 1
) (
  input  logic [WAYS-1:0][IDXW-1:0]  order,
  input  logic [WAYS-1:0]            valid,
  input  logic [WAYS-1:0]            dirty,
  input  logic [WINW-1:0]            win_raw,
  output logic [IDXW-1:0]            victim_way,
  output logic                       victim_dirty,
  output victim_src_e                victim_src
);
  int unsigned     win;
  logic            any_inv;
  logic [IDXW-1:0] inv_way;
  logic            clean_found;
  logic [IDXW-1:0] clean_way;

  assign win = clamp_window(int'(win_raw), WAYS);

  // Lowest-numbered invalid way: scan downward, last hit wins.
  always_comb begin
    any_inv = 1'b0;
    inv_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[w]) begin
        any_inv = 1'b1;
        inv_way = IDXW'(w);
      end
    end
  end

  // Oldest clean way inside the window: scan from the newest window slot down.
  always_comb begin
    clean_found = 1'b0;
    clean_way   = '0;
    for (int p = WAYS - 1; p >= 0; p--) begin
      if (p < int'(win) && !dirty[order[p]]) begin
        clean_found = 1'b1;
        clean_way   = order[p];
      end
    end
  end

  always_comb begin
    if (any_inv) begin
      victim_src   = SRC_INVALID;
      victim_way   = inv_way;
      victim_dirty = 1'b0;
    end else if (clean_found) begin
      victim_src   = SRC_CLEAN;
      victim_way   = clean_way;
      victim_dirty = 1'b0;
    end else begin
      victim_src   = SRC_LRU;
      victim_way   = order[0];
      victim_dirty = 1'b1;
    end
  end

endmodule

// File: rtl/cfw_victim_sel.sv
module cfw_victim_sel
  import cfw_pkg::*;
#(
  parameter int WAYS = 16,
  parameter int IDXW = $clog2(WAYS),
  parameter int WINW = $clog2(WAYS) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic             acc_hit,
  input  logic [IDXW-1:0]  acc_way,
  input  logic             acc_write,
  input  logic [WINW-1:0]  win_n,
  output logic [IDXW-1:0]  victim_way,
  output logic             victim_dirty
);
  logic [WAYS-1:0][IDXW-1:0] order;
  logic [WAYS-1:0]           valid;
  logic [WAYS-1:0]           dirty;
  logic [IDXW-1:0]           touch_way;
  victim_src_e               victim_src;
  logic                      set_full;

  assign touch_way = acc_hit ? acc_way : victim_way;
  assign set_full  = &valid;

  cfw_recency #(.WAYS(WAYS), .IDXW(IDXW)) u_recency (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_en  (acc_valid),
    .touch_way (touch_way),
    .order     (order)
  );

  cfw_line_state #(.WAYS(WAYS), .IDXW(IDXW)) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_en    (acc_valid),
    .acc_hit   (acc_hit),
    .acc_wr    (acc_write),
    .touch_way (touch_way),
    .valid     (valid),
    .dirty     (dirty)
  );

  cfw_victim_pick #(.WAYS(WAYS), .IDXW(IDXW), .WINW(WINW)) u_pick (
    .order        (order),
    .valid        (valid),
    .dirty        (dirty),
    .win_raw      (win_n),
    .victim_way   (victim_way),
    .victim_dirty (victim_dirty),
    .victim_src   (victim_src)
  );

  // R2: with a hole in the set, an invalid clean way is chosen
  assert_inv_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !set_full |-> (!valid[victim_way] && !victim_dirty && victim_src == SRC_INVALID));
  // R5: a clean-flagged victim in a full set really is clean
  assert_clean_pick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (set_full && !victim_dirty) |-> !dirty[victim_way]);
  // R6: a dirty victim is the true LRU way and is dirty
  assert_fallback_R6: assert property (@(posedge clk) disable iff (!rst_n)
    victim_dirty |-> (victim_way == order[0] && dirty[victim_way]));
  // R7: window of one gives plain LRU once the set is full
  assert_lru_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_full && win_n <= WINW'(1)) |-> victim_way == order[0]);
  // R8: full window reports dirty only when the whole set is dirty
  assert_full_win_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_full && win_n >= WINW'(WAYS) && victim_dirty) |-> &dirty);

endmodule

// File: tb/tb_cfw_victim_sel.sv
module tb_cfw_victim_sel;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0;
  logic       acc_hit = 1'b0;
  logic [3:0] acc_way = '0;
  logic       acc_write = 1'b0;
  logic [4:0] win_n = 5'd1;
  logic [3:0] victim_way;
  logic       victim_dirty;

  int checks = 0;
  int errors = 0;

  // Independent model: per-way last-touch timestamp, valid, dirty.
  int m_stamp [WAYS];
  bit m_valid [WAYS];
  bit m_dirty [WAYS];
  int m_time;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfw_victim_sel dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
    .acc_way(acc_way), .acc_write(acc_write), .win_n(win_n),
    .victim_way(victim_way), .victim_dirty(victim_dirty)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int w = 0; w < WAYS; w++) begin
      m_stamp[w] = w; m_valid[w] = 0; m_dirty[w] = 0;
    end
    m_time = WAYS;
  endtask

  task automatic model_victim(int n, output int way, output int drt);
    int rank, best;
    way = -1; drt = 0;
    if (n < 1) n = 1;
    if (n > WAYS) n = WAYS;
    for (int w = 0; w < WAYS; w++)
      if (!m_valid[w] && way < 0) way = w;
    if (way >= 0) return;
    best = -1;
    for (int w = 0; w < WAYS; w++) begin
      rank = 0;
      for (int v = 0; v < WAYS; v++) if (m_stamp[v] < m_stamp[w]) rank++;
      if (rank < n && !m_dirty[w] && (best < 0 || m_stamp[w] < m_stamp[best])) best = w;
    end
    if (best >= 0) begin way = best; return; end
    way = 0;
    for (int w = 1; w < WAYS; w++) if (m_stamp[w] < m_stamp[way]) way = w;
    drt = 1;
  endtask

  task automatic probe(int n, string req);
    int ew, ed;
    @(negedge clk);
    win_n = 5'(n);
    #1;
    model_victim(n, ew, ed);
    check({req, " way"}, int'(victim_way), ew);
    check({req, " dirty"}, int'(victim_dirty), ed);
  endtask

  task automatic access(bit hit, int way, bit wr);
    int tw, td;
    @(negedge clk);
    acc_valid = 1'b1; acc_hit = hit; acc_way = 4'(way); acc_write = wr;
    model_victim(int'(win_n), tw, td);
    if (hit) tw = way;
    @(posedge clk);
    #1;
    acc_valid = 1'b0;
    m_stamp[tw] = m_time++;
    if (!hit) begin m_valid[tw] = 1; m_dirty[tw] = wr; end
    else if (wr) m_dirty[tw] = 1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    model_reset();
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
    probe(1, "R1 reset");
    check("R1 reset way0", int'(victim_way), 0);
    check("R1 reset clean", int'(victim_dirty), 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < WAYS; i++) begin
      probe((i % 2 == 0) ? 16 : 3, "R2 invalid first");
      check("R2 lowest invalid", int'(victim_way), i);
      access(1'b0, 0, (i == 5));
    end
    probe(1, "R7 lru after fill");
    probe(8, "R5 clean in window");
  endtask

  task automatic t_promote();
    access(1'b1, 0, 1'b0);
    probe(1, "R3 promote");
    check("R3 way1 now lru", int'(victim_way), 1);
  endtask

  task automatic t_dirty_fallback();
    for (int w = 0; w < WAYS; w++) access(1'b1, w, 1'b1);
    probe(4, "R6 all dirty n4");
    check("R6 fallback lru", int'(victim_way), 0);
    check("R6 flag", int'(victim_dirty), 1);
    access(1'b1, 0, 1'b0);
    probe(16, "R4 read hit keeps dirty");
    check("R4 read hit keeps dirty way", int'(victim_way), 1);
    check("R4 read hit keeps dirty flag", int'(victim_dirty), 1);
    access(1'b0, 0, 1'b0);
    probe(16, "R8 clean at mru");
    check("R8 clean way", int'(victim_way), 1);
    check("R8 clean flag", int'(victim_dirty), 0);
    probe(12, "R6 clean outside window");
    check("R6 outside window way", int'(victim_way), 2);
    probe(0, "R9 zero acts as one");
    check("R9 zero way", int'(victim_way), 2);
    probe(31, "R9 large acts as full");
    check("R9 large way", int'(victim_way), 1);
    probe(17, "R9 seventeen");
    access(1'b0, 0, 1'b1);
    probe(16, "R4 write fill dirty");
    check("R4 write fill dirty flag", int'(victim_dirty), 1);
  endtask

  task automatic t_scramble();
    logic [15:0] lfsr = 16'hACE1;
    int sizes [5] = '{1, 4, 8, 12, 16};
    for (int s = 0; s < 300; s++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      probe(sizes[lfsr[2:0] % 5], "R5 mixed");
      access(lfsr[3] | lfsr[4], int'(lfsr[11:8]), lfsr[6] & ~lfsr[7]);
    end
    probe(1, "R7 mixed end");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_fill();
    t_promote();
    t_dirty_fallback();
    t_scramble();
    t_reset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule